// File: doc/BRIEF.md
# Three-State Coherent Tag Controller with Snoop Priority

This block keeps the tag and coherence state of every line of a direct-indexed cache. Each line is Invalid, Exclusive or Modified; there is no shared state. A single-ported tag/state array serves two requesters: the local load/store path (loads, stores and line fills) and a bus snoop port. The block looks up the addressed line, reports hit or miss and the line state, and updates the state as local stores, fills and snoop hits require.

A snoop always owns the array in the cycle it arrives. A local request that arrives in the same cycle is held in a one-entry slot and carried out on the next clock, with its original index, tag and operation. It sees whatever state change the snoop has just made. A snoop hit to a Modified line raises a writeback request carrying the line index, and the line becomes Invalid. Data storage, the writeback data path, bus signalling and replacement choice belong to other blocks.

The environment issues a local request only while `lcl_ready` is high. It never issues snoops in two consecutive cycles, so a held local access always runs exactly one clock after its arrival.

Top module: `mei_tag_ctrl`

## Requirements
- R1: Line states use 2 bits: Invalid 00, Exclusive 01, Modified 10; 11 is never reported. Reset makes every line Invalid, so every lookup after reset misses.
- R2: A local load (lcl_op 00, and the unused code 11) hits only when the line is not Invalid and its stored tag equals lcl_tag. On a hit it reports the line state; on a miss it reports 00, whatever tag is stored. A load changes no state.
- R3: A line fill (lcl_op 10) writes lcl_tag into the line and sets it to Exclusive, whatever its prior content.
- R4: A local store (lcl_op 01) that hits an Exclusive or Modified line leaves it Modified. A store that misses changes nothing.
- R5: A snoop that hits a Modified line asserts wb_req with wb_idx equal to the snooped index for one cycle, and the line becomes Invalid.
- R6: A snoop that hits an Exclusive line makes it Invalid without wb_req. A snoop that misses reports snp_hit low and changes no state.
- R7: When a snoop and a local request arrive in the same cycle, the snoop accesses the array in that cycle and the local access runs on the next clock with its original operation, index and tag. It observes the state written by the snoop.
- R8: A result appears one clock after the cycle in which its access uses the array: lcl_done (or snp_done) pulses high for one cycle with the hit and state. At most one of lcl_done and snp_done is high in any cycle.
- R9: lcl_ready is low for exactly the cycle in which a held local access waits to run, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present this cycle |
| lcl_op | input | 2 | Local operation: 00 load, 01 store, 10 fill |
| lcl_idx | input | IDX_W | Local line index |
| lcl_tag | input | TAG_W | Local address tag |
| lcl_ready | output | 1 | Local request may be issued this cycle |
| snp_valid | input | 1 | Snoop present this cycle |
| snp_idx | input | IDX_W | Snooped line index |
| snp_tag | input | TAG_W | Snooped address tag |
| lcl_done | output | 1 | Local result valid |
| lcl_hit | output | 1 | Local lookup hit |
| lcl_state | output | 2 | State of the line on hit, 00 on miss |
| snp_done | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snoop hit a valid line |
| wb_req | output | 1 | Modified line must be written back |
| wb_idx | output | IDX_W | Index of the line to write back |

## Verification
The bench builds the controller with IDX_W=3 and TAG_W=4. Eight lines and a narrow tag space make random snoops and loads hit installed lines often. This brings Modified-line snoops, same-line collisions and tag-mismatch misses on valid lines within reach of a few thousand random cycles. Directed sequences add a collision in which the snoop invalidates a Modified line just before the held store to that line, and a collision in which a missing snoop leaves the held load to hit.

// File: rtl/mei_pkg.sv
package mei_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_EXC = 2'b01,
        ST_MOD = 2'b10
    } line_st_e;

    localparam logic [1:0] OP_LOAD  = 2'b00;
    localparam logic [1:0] OP_STORE = 2'b01;
    localparam logic [1:0] OP_FILL  = 2'b10;

endpackage

// File: rtl/mei_tag_array.sv
module mei_tag_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     acc_idx,
    output logic [TAG_W-1:0]     rd_tag,
    output mei_pkg::line_st_e    rd_st,
    input  logic                 wr_en,
    input  logic                 wr_tag_en,
    input  logic [TAG_W-1:0]     wr_tag,
    input  mei_pkg::line_st_e    wr_st
);
    import mei_pkg::*;

    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    line_st_e         st_d  [LINES];
    line_st_e         st_q  [LINES];

    // one shared port: the same index addresses the read and the write
    assign rd_tag = tag_q[acc_idx];
    assign rd_st  = st_q[acc_idx];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            tag_d[i] = tag_q[i];
            st_d[i]  = st_q[i];
        end
        if (wr_en) begin
            st_d[acc_idx] = wr_st;
            if (wr_tag_en) begin
                tag_d[acc_idx] = wr_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_INV;
            end else begin
                tag_q[i] <= tag_d[i];
                st_q[i]  <= st_d[i];
            end
        end
    end

endmodule

// File: rtl/mei_access_arb.sv
module mei_access_arb #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  logic [1:0]       lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    input  logic [TAG_W-1:0] lcl_tag,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             acc_valid,
    output logic             acc_snp,
    output logic [1:0]       acc_op,
    output logic [IDX_W-1:0] acc_idx,
    output logic [TAG_W-1:0] acc_tag,
    output logic             lcl_ready
);
    import mei_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [1:0]       op;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d    = hold_q;
        acc_valid = 1'b0;
        acc_snp   = 1'b0;
        acc_op    = lcl_op;
        acc_idx   = lcl_idx;
        acc_tag   = lcl_tag;
        if (snp_valid) begin
            // snoop owns the port; a colliding local request is parked
            acc_valid = 1'b1;
            acc_snp   = 1'b1;
            acc_op    = OP_LOAD;
            acc_idx   = snp_idx;
            acc_tag   = snp_tag;
            if (lcl_valid && !hold_q.vld) begin
                hold_d.vld = 1'b1;
                hold_d.op  = lcl_op;
                hold_d.idx = lcl_idx;
                hold_d.tag = lcl_tag;
            end
        end else if (hold_q.vld) begin
            acc_valid  = 1'b1;
            acc_op     = hold_q.op;
            acc_idx    = hold_q.idx;
            acc_tag    = hold_q.tag;
            hold_d.vld = 1'b0;
        end else if (lcl_valid) begin
            acc_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign lcl_ready = !hold_q.vld;

endmodule

// File: rtl/mei_coh_update.sv
module mei_coh_update #(
    parameter int TAG_W = 8
) (
    input  logic              acc_valid,
    input  logic              acc_snp,
    input  logic [1:0]        acc_op,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [TAG_W-1:0]  rd_tag,
    input  mei_pkg::line_st_e rd_st,
    output logic              hit,
    output logic              wr_en,
    output logic              wr_tag_en,
    output mei_pkg::line_st_e wr_st,
    output logic              wb
);
    import mei_pkg::*;

    always_comb begin
        hit       = acc_valid && (rd_st != ST_INV) && (rd_tag == acc_tag);
        wr_en     = 1'b0;
        wr_tag_en = 1'b0;
        wr_st     = rd_st;
        wb        = 1'b0;
        if (acc_valid) begin
            if (acc_snp) begin
                if (hit) begin
                    wr_en = 1'b1;
                    wr_st = ST_INV;
                    wb    = (rd_st == ST_MOD);
                end
            end else begin
                case (acc_op)
                    OP_FILL: begin
                        wr_en     = 1'b1;
                        wr_tag_en = 1'b1;
                        wr_st     = ST_EXC;
                    end
                    OP_STORE: begin
                        if (hit) begin
                            wr_en = 1'b1;
                            wr_st = ST_MOD;
                        end
                    end
                    default: begin
                        wr_en = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mei_tag_ctrl.sv
module mei_tag_ctrl #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcl_valid,
    input  logic [1:0]       lcl_op,
    input  logic [IDX_W-1:0] lcl_idx,
    input  logic [TAG_W-1:0] lcl_tag,
    output logic             lcl_ready,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             lcl_done,
    output logic             lcl_hit,
    output logic [1:0]       lcl_state,
    output logic             snp_done,
    output logic             snp_hit,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);
    import mei_pkg::*;

    typedef struct packed {
        logic             l_done;
        logic             l_hit;
        logic [1:0]       l_st;
        logic             s_done;
        logic             s_hit;
        logic             wb;
        logic [IDX_W-1:0] wb_idx;
    } resp_t;

    logic             acc_valid;
    logic             acc_snp;
    logic [1:0]       acc_op;
    logic [IDX_W-1:0] acc_idx;
    logic [TAG_W-1:0] acc_tag;
    logic [TAG_W-1:0] rd_tag;
    line_st_e         rd_st;
    logic             hit;
    logic             wr_en;
    logic             wr_tag_en;
    line_st_e         wr_st;
    logic             wb;
    resp_t            resp_d, resp_q;

    mei_access_arb #(.IDX_W(IDX_W), .TAG_W(TAG_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcl_valid (lcl_valid),
        .lcl_op    (lcl_op),
        .lcl_idx   (lcl_idx),
        .lcl_tag   (lcl_tag),
        .snp_valid (snp_valid),
        .snp_idx   (snp_idx),
        .snp_tag   (snp_tag),
        .acc_valid (acc_valid),
        .acc_snp   (acc_snp),
        .acc_op    (acc_op),
        .acc_idx   (acc_idx),
        .acc_tag   (acc_tag),
        .lcl_ready (lcl_ready)
    );

    mei_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_idx   (acc_idx),
        .rd_tag    (rd_tag),
        .rd_st     (rd_st),
        .wr_en     (wr_en),
        .wr_tag_en (wr_tag_en),
        .wr_tag    (acc_tag),
        .wr_st     (wr_st)
    );

    mei_coh_update #(.TAG_W(TAG_W)) upd_i (
        .acc_valid (acc_valid),
        .acc_snp   (acc_snp),
        .acc_op    (acc_op),
        .acc_tag   (acc_tag),
        .rd_tag    (rd_tag),
        .rd_st     (rd_st),
        .hit       (hit),
        .wr_en     (wr_en),
        .wr_tag_en (wr_tag_en),
        .wr_st     (wr_st),
        .wb        (wb)
    );

    always_comb begin
        resp_d        = '0;
        resp_d.l_done = acc_valid && !acc_snp;
        resp_d.l_hit  = hit && !acc_snp;
        resp_d.l_st   = (hit && !acc_snp) ? rd_st : ST_INV;
        resp_d.s_done = acc_valid && acc_snp;
        resp_d.s_hit  = hit && acc_snp;
        resp_d.wb     = wb;
        resp_d.wb_idx = wb ? acc_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign lcl_done  = resp_q.l_done;
    assign lcl_hit   = resp_q.l_hit;
    assign lcl_state = resp_q.l_st;
    assign snp_done  = resp_q.s_done;
    assign snp_hit   = resp_q.s_hit;
    assign wb_req    = resp_q.wb;
    assign wb_idx    = resp_q.wb_idx;

endmodule

// File: rtl/mei_tag_ctrl_chk.sv
module mei_tag_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lcl_valid,
    input logic             lcl_ready,
    input logic             snp_valid,
    input logic [IDX_W-1:0] snp_idx,
    input logic             lcl_done,
    input logic             lcl_hit,
    input logic [1:0]       lcl_state,
    input logic             snp_done,
    input logic             snp_hit,
    input logic             wb_req,
    input logic [IDX_W-1:0] wb_idx
);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_state != 2'b11);  // R1

    AST_MISS_REPORTS_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_done && !lcl_hit) |-> (lcl_state == 2'b00));  // R2

    AST_WB_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (snp_done && snp_hit && $past(snp_valid) && ($past(snp_idx) == wb_idx)));  // R5

    AST_MISS_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_done && !snp_hit) |-> !wb_req);  // R6

    AST_DEFER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && lcl_valid && lcl_ready) |=> (!lcl_done ##1 lcl_done));  // R7

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcl_done && snp_done));  // R8

    AST_SNP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_done);  // R8

    AST_LCL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_ready && !snp_valid) |=> lcl_done);  // R8

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && lcl_valid && lcl_ready) |=> !lcl_ready);  // R9

endmodule

bind mei_tag_ctrl mei_tag_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcl_valid (lcl_valid),
    .lcl_ready (lcl_ready),
    .snp_valid (snp_valid),
    .snp_idx   (snp_idx),
    .lcl_done  (lcl_done),
    .lcl_hit   (lcl_hit),
    .lcl_state (lcl_state),
    .snp_done  (snp_done),
    .snp_hit   (snp_hit),
    .wb_req    (wb_req),
    .wb_idx    (wb_idx)
);

// File: tb/mei_tag_ctrl_tb_top.sv
module mei_tag_ctrl_tb_top;

    localparam int IDX_W = 3;
    localparam int TAG_W = 4;
    localparam int LINES = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lcl_valid = 1'b0;
    logic [1:0]       lcl_op = 2'b00;
    logic [IDX_W-1:0] lcl_idx = '0;
    logic [TAG_W-1:0] lcl_tag = '0;
    logic             lcl_ready;
    logic             snp_valid = 1'b0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic [TAG_W-1:0] snp_tag = '0;
    logic             lcl_done, lcl_hit, snp_done, snp_hit, wb_req;
    logic [1:0]       lcl_state;
    logic [IDX_W-1:0] wb_idx;

    always #2.5 clk = ~clk;

    mei_tag_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx), .lcl_tag(lcl_tag),
        .lcl_ready(lcl_ready),
        .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_tag(snp_tag),
        .lcl_done(lcl_done), .lcl_hit(lcl_hit), .lcl_state(lcl_state),
        .snp_done(snp_done), .snp_hit(snp_hit), .wb_req(wb_req), .wb_idx(wb_idx)
    );

    int total = 0;
    int bad   = 0;

    // reference model of the array and the held slot
    int m_tag [LINES];
    int m_st  [LINES];
    bit p_v;
    int p_op, p_idx, p_tag;

    // expectations for the next negedge
    bit    e_ld, e_lh, e_sd, e_sh, e_wb;
    int    e_ls, e_wi;
    string e_lq, e_sq;
    string phase_tag = "";
    bit    prev_sv;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic bit lk_hit(input int idx, input int tag);
        return (m_st[idx] != 0) && (m_tag[idx] == tag);
    endfunction

    task automatic model_local(input int op, input int idx, input int tag, input string rq);
        bit h;
        h    = lk_hit(idx, tag);
        e_ld = 1'b1;
        e_lh = h;
        e_ls = h ? m_st[idx] : 0;
        e_lq = rq;
        if (op == 2) begin
            m_tag[idx] = tag;
            m_st[idx]  = 1;
        end else if (op == 1 && h) begin
            m_st[idx] = 2;
        end
    endtask

    function automatic string op_tag(input int op);
        if (phase_tag != "") return phase_tag;
        if (op == 2) return "R3";
        if (op == 1) return "R4";
        return "R2";
    endfunction

    task automatic compare();
        chk("R9", "lcl_ready", int'(lcl_ready), int'(!p_v));
        chk("R8", "lcl_done", int'(lcl_done), int'(e_ld));
        if (e_ld && lcl_done) begin
            chk(e_lq, "lcl_hit", int'(lcl_hit), int'(e_lh));
            chk(e_lq, "lcl_state", int'(lcl_state), e_ls);
        end
        chk("R8", "snp_done", int'(snp_done), int'(e_sd));
        if (e_sd && snp_done) begin
            chk(e_sq, "snp_hit", int'(snp_hit), int'(e_sh));
            chk(e_sq, "wb_req", int'(wb_req), int'(e_wb));
            if (e_wb) chk("R5", "wb_idx", int'(wb_idx), e_wi);
        end else begin
            chk("R6", "wb_req idle", int'(wb_req), 0);
        end
    endtask

    task automatic step(input bit lv, input int lop, input int lidx, input int ltag,
                        input bit sv, input int sidx, input int stag);
        @(negedge clk);
        compare();
        lcl_valid = lv;
        lcl_op    = 2'(lop);
        lcl_idx   = IDX_W'(lidx);
        lcl_tag   = TAG_W'(ltag);
        snp_valid = sv;
        snp_idx   = IDX_W'(sidx);
        snp_tag   = TAG_W'(stag);
        e_ld = 1'b0; e_sd = 1'b0; e_wb = 1'b0; e_sh = 1'b0; e_lh = 1'b0;
        if (sv) begin
            bit h;
            h    = lk_hit(sidx, stag);
            e_sd = 1'b1;
            e_sh = h;
            e_wb = h && (m_st[sidx] == 2);
            e_wi = sidx;
            e_sq = e_wb ? "R5" : "R6";
            if (h) m_st[sidx] = 0;
            if (lv && !p_v) begin
                p_v = 1'b1; p_op = lop; p_idx = lidx; p_tag = ltag;
            end
        end else if (p_v) begin
            p_v = 1'b0;
            model_local(p_op, p_idx, p_tag, "R7");   // deferred access
        end else if (lv) begin
            model_local(lop, lidx, ltag, op_tag(lop));
        end
        prev_sv = sv;
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = 0;
            m_st[i]  = 0;
        end
        p_v = 1'b0;
        prev_sv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state at the ports
        chk("R1", "lcl_done after reset", int'(lcl_done), 0);
        chk("R1", "snp_done after reset", int'(snp_done), 0);
        chk("R1", "wb_req after reset", int'(wb_req), 0);

        // R1: every line misses after reset (tag 0 matches reset tag value)
        phase_tag = "R1";
        for (int i = 0; i < LINES; i++) step(1'b1, 0, i, 0, 1'b0, 0, 0);
        phase_tag = "";

        // R3 fill then R2 hit/miss on tag
        step(1'b1, 2, 1, 5, 1'b0, 0, 0);
        step(1'b1, 0, 1, 5, 1'b0, 0, 0);
        step(1'b1, 0, 1, 6, 1'b0, 0, 0);
        // R4 store hit -> Modified, store miss leaves line alone
        step(1'b1, 1, 1, 5, 1'b0, 0, 0);
        step(1'b1, 0, 1, 5, 1'b0, 0, 0);
        step(1'b1, 1, 2, 5, 1'b0, 0, 0);
        step(1'b1, 0, 2, 5, 1'b0, 0, 0);
        // R5 snoop on Modified line, then line is gone
        step(1'b0, 0, 0, 0, 1'b1, 1, 5);
        step(1'b1, 0, 1, 5, 1'b0, 0, 0);
        // R6 snoop on Exclusive, then snoop miss
        step(1'b1, 2, 3, 2, 1'b0, 0, 0);
        step(1'b0, 0, 0, 0, 1'b1, 3, 2);
        step(1'b1, 0, 3, 2, 1'b0, 0, 0);
        step(1'b1, 2, 4, 7, 1'b0, 0, 0);
        step(1'b0, 0, 0, 0, 1'b1, 4, 8);
        step(1'b1, 0, 4, 7, 1'b0, 0, 0);
        // R7 collision: snoop invalidates Modified line ahead of held store
        step(1'b1, 2, 6, 1, 1'b0, 0, 0);
        step(1'b1, 1, 6, 1, 1'b0, 0, 0);
        step(1'b1, 1, 6, 1, 1'b1, 6, 1);
        idle();
        step(1'b1, 0, 6, 1, 1'b0, 0, 0);
        // R7 collision: snoop misses, held load still hits Exclusive
        step(1'b1, 2, 7, 3, 1'b0, 0, 0);
        step(1'b1, 0, 7, 3, 1'b1, 7, 9);
        idle();
        idle();

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit sv, lv;
            int op;
            sv = !prev_sv && ($urandom_range(0, 9) < 3);
            lv = !p_v && ($urandom_range(0, 9) < 6);
            op = $urandom_range(0, 9);
            op = (op < 4) ? 0 : (op < 7) ? 1 : (op < 9) ? 2 : 3;
            step(lv, op, $urandom_range(0, LINES - 1), $urandom_range(0, 2),
                 sv, $urandom_range(0, LINES - 1), $urandom_range(0, 2));
        end
        idle();
        idle();
        @(negedge clk);
        compare();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule